// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block collects up to 64 interrupt sources and reports them to a processor through two request lines and a readable entry word. Each source carries a 3-bit priority, where 0 is the most urgent. A request seen on a source input is latched as pending. It goes into one of two pending banks, chosen by the source's priority at capture time. Priorities 0 and 1 go to the fast bank, which drives the fast request line. Priorities 2 to 7 go to the normal bank, which drives the normal request line. Software acknowledges a request by writing a one to its pending bit.

Enable bits mask sources without discarding their pending state. An arbiter picks the enabled pending source with the lowest priority value, and the lowest index wins a tie. The entry word then reads as a programmable base plus four times (index + 1), so software recovers the source as (entry − base) / 4 − 1. A control bit narrows the entry word to normal-bank sources only.

Every register sits on a plain 32-bit word bus with a write strobe, a read strobe and a byte address. Read data is combinational.

Top module: `prio_vec_intc`

## Requirements
- R1: When a source input is high at a clock edge, its pending bit is set. It goes to the fast bank if the source's priority is 0 or 1, and to the normal bank otherwise. Fast pending reads at byte offsets 0x00 and 0x04, normal pending at 0x08 and 0x0C, and source n sits in bit n%32 of word n/32.
- R2: Writing a one to a pending bit clears it. Writing a zero leaves it unchanged.
- R3: Enables read and write at 0x18 and 0x1C, with the same bit placement as pending, and reset to 0. A cleared enable stops the source from reaching the request lines and the entry word from the next cycle on, while its pending bit is kept.
- R4: Priorities live at 0x30 to 0x4C. Source n uses word n/8, bits [4*(n%8)+2 : 4*(n%8)]. The fourth bit of each nibble ignores writes and reads 0.
- R5: A request arriving in the same cycle as a write-one-to-clear of its bit leaves the bit pending.
- R6: The fast and normal request lines are registered. Each is high exactly one cycle after its bank has an enabled pending source.
- R7: The entry word at 0x14 reads base + 4*(winner+1). The winner has the lowest priority value, and the lowest index wins a tie.
- R8: With no source eligible, the entry word reads the base alone.
- R9: The entry base at 0x24 stores bits 31..2. Bits 1..0 read 0.
- R10: Control bit 0 at 0x20, when 0, lets both banks compete for the entry word. When 1, only normal-bank sources compete. The other control bits read 0.
- R11: Only address bits 7..2 are decoded. Undefined offsets read 0.
- R12: After reset, all pending, enable, priority, control and base state is 0 and both request lines are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_req | input | NUM_SRC | Source request inputs, sampled every edge |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, 0 when no read |
| fast_int_o | output | 1 | Fast interrupt request |
| norm_int_o | output | 1 | Normal interrupt request |

## Verification
Two things can hit the same pending bit in the same cycle: capture of a new request and a write-one-to-clear acknowledge. The bench provokes this by driving a source pulse and an acknowledge write for that bit across the same clock edge. It then reads the pending word back and expects the bit still set. Writes that change enables, priorities, control or base are followed at once by entry-word reads, which judge the one-cycle update path against hand-computed values.

// File: rtl/pvic_pkg.sv
package pvic_pkg;
   localparam int WIDX_W  = 6;   // decoded word index = addr[7:2]
   localparam int W_FPEND = 0;   // fast pending words 0,1
   localparam int W_NPEND = 2;   // normal pending words 2,3
   localparam int W_ENTRY = 5;
   localparam int W_EN    = 6;   // enable words 6,7
   localparam int W_CTRL  = 8;
   localparam int W_BASE  = 9;
   localparam int W_PRIO  = 12;  // priority words 12..19
   localparam int NIB_W   = 4;
   localparam int SRC_PER_WORD  = 32;
   localparam int SRC_PER_PRIO  = 8;

   typedef logic [WIDX_W-1:0] widx_t;
   typedef logic [31:0]       word_t;
endpackage

// File: rtl/pvic_regfile.sv
module pvic_regfile
   import pvic_pkg::*;
#(
   parameter int NUM_SRC  = 64,
   parameter int ADDR_W   = 12,
   parameter int PRIO_W   = 3,
   parameter int FAST_MAX = 1
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic [NUM_SRC-1:0]              src_req,
   input  logic                            bus_wr,
   input  logic                            bus_rd,
   input  logic [ADDR_W-1:0]               bus_addr,
   input  logic [31:0]                     bus_wdata,
   output logic [31:0]                     bus_rdata,
   input  logic [31:0]                     entry_q,
   output logic [NUM_SRC-1:0]              fast_pend,
   output logic [NUM_SRC-1:0]              norm_pend,
   output logic [NUM_SRC-1:0]              en_q,
   output logic [NUM_SRC-1:0][PRIO_W-1:0]  prio_q,
   output logic                            ctrl_mode,
   output logic [31:0]                     base_q
);
   localparam int NW = NUM_SRC / SRC_PER_WORD;
   localparam int NP = NUM_SRC / SRC_PER_PRIO;

   widx_t widx;
   logic [29:0] base_hi;
   logic        unused_addr;

   assign widx        = bus_addr[7:2];
   assign unused_addr = ^{bus_addr[1:0], bus_addr[ADDR_W-1:8]};
   assign base_q      = {base_hi, 2'b00};

   // per-source pending capture, class routing and write-one-to-clear
   for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
      localparam widx_t K_F = widx_t'(W_FPEND + i / SRC_PER_WORD);
      localparam widx_t K_N = widx_t'(W_NPEND + i / SRC_PER_WORD);
      localparam widx_t K_P = widx_t'(W_PRIO + i / SRC_PER_PRIO);
      localparam int    BIT = i % SRC_PER_WORD;
      localparam int    NIB = (i % SRC_PER_PRIO) * NIB_W;
      logic is_fast, clr_f, clr_n;

      assign is_fast = (int'(prio_q[i]) <= FAST_MAX);
      assign clr_f   = bus_wr && (widx == K_F) && bus_wdata[BIT];
      assign clr_n   = bus_wr && (widx == K_N) && bus_wdata[BIT];

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            fast_pend[i] <= 1'b0;
            norm_pend[i] <= 1'b0;
            prio_q[i]    <= '0;
         end else begin
            fast_pend[i] <= (fast_pend[i] && !clr_f) || (src_req[i] && is_fast);
            norm_pend[i] <= (norm_pend[i] && !clr_n) || (src_req[i] && !is_fast);
            if (bus_wr && widx == K_P)
               prio_q[i] <= bus_wdata[NIB +: PRIO_W];
         end
      end
   end

   // enable words
   for (genvar w = 0; w < NW; w++) begin : g_en
      localparam widx_t K_E = widx_t'(W_EN + w);
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            en_q[w*SRC_PER_WORD +: SRC_PER_WORD] <= '0;
         else if (bus_wr && widx == K_E)
            en_q[w*SRC_PER_WORD +: SRC_PER_WORD] <= bus_wdata;
      end
   end

   // control and base
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_mode <= 1'b0;
         base_hi   <= '0;
      end else if (bus_wr) begin
         if (widx == widx_t'(W_CTRL)) ctrl_mode <= bus_wdata[0];
         if (widx == widx_t'(W_BASE)) base_hi   <= bus_wdata[31:2];
      end
   end

   // read mux
   always_comb begin
      bus_rdata = '0;
      if (bus_rd) begin
         for (int w = 0; w < NW; w++) begin
            if (widx == widx_t'(W_FPEND + w))
               bus_rdata = fast_pend[w*SRC_PER_WORD +: SRC_PER_WORD];
            if (widx == widx_t'(W_NPEND + w))
               bus_rdata = norm_pend[w*SRC_PER_WORD +: SRC_PER_WORD];
            if (widx == widx_t'(W_EN + w))
               bus_rdata = en_q[w*SRC_PER_WORD +: SRC_PER_WORD];
         end
         for (int r = 0; r < NP; r++) begin
            if (widx == widx_t'(W_PRIO + r)) begin
               for (int n = 0; n < SRC_PER_PRIO; n++)
                  bus_rdata[n*NIB_W +: PRIO_W] = prio_q[r*SRC_PER_PRIO + n];
            end
         end
         if (widx == widx_t'(W_ENTRY)) bus_rdata = entry_q;
         if (widx == widx_t'(W_CTRL))  bus_rdata = {31'b0, ctrl_mode};
         if (widx == widx_t'(W_BASE))  bus_rdata = base_q;
      end
   end
endmodule

// File: rtl/pvic_arbiter.sv
module pvic_arbiter #(
   parameter int NUM_SRC  = 64,
   parameter int PRIO_W   = 3,
   parameter bit ARB_TREE = 1'b1,
   localparam int IDX_W   = $clog2(NUM_SRC)
) (
   input  logic [NUM_SRC-1:0]             act,
   input  logic [NUM_SRC-1:0][PRIO_W-1:0] prio,
   output logic                           win_vld,
   output logic [IDX_W-1:0]               win_idx
);
   localparam int LEAVES = 1 << IDX_W;

   if (ARB_TREE) begin : g_tree
      // heap layout: node k has children 2k and 2k+1, leaves at LEAVES..2*LEAVES-1
      logic              h_v [1:2*LEAVES-1];
      logic [PRIO_W-1:0] h_p [1:2*LEAVES-1];
      logic [IDX_W-1:0]  h_i [1:2*LEAVES-1];

      for (genvar j = 0; j < LEAVES; j++) begin : g_leaf
         if (j < NUM_SRC) begin : g_real
            assign h_v[LEAVES+j] = act[j];
            assign h_p[LEAVES+j] = prio[j];
         end else begin : g_pad
            assign h_v[LEAVES+j] = 1'b0;
            assign h_p[LEAVES+j] = '1;
         end
         assign h_i[LEAVES+j] = IDX_W'(j);
      end

      for (genvar k = 1; k < LEAVES; k++) begin : g_node
         logic take_l;
         // left child holds lower indices, so it keeps ties
         assign take_l = h_v[2*k] && (!h_v[2*k+1] || h_p[2*k] <= h_p[2*k+1]);
         assign h_v[k] = h_v[2*k] || h_v[2*k+1];
         assign h_p[k] = take_l ? h_p[2*k] : h_p[2*k+1];
         assign h_i[k] = take_l ? h_i[2*k] : h_i[2*k+1];
      end

      assign win_vld = h_v[1];
      assign win_idx = h_i[1];
   end else begin : g_linear
      logic [PRIO_W-1:0] best_p;
      always_comb begin
         win_vld = 1'b0;
         win_idx = '0;
         best_p  = '1;
         for (int i = NUM_SRC - 1; i >= 0; i--) begin
            if (act[i] && (!win_vld || prio[i] <= best_p)) begin
               win_vld = 1'b1;
               win_idx = IDX_W'(i);
               best_p  = prio[i];
            end
         end
      end
   end
endmodule

// File: rtl/pvic_entry.sv
module pvic_entry #(
   parameter int NUM_SRC  = 64,
   parameter int PRIO_W   = 3,
   parameter bit ARB_TREE = 1'b1
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic [NUM_SRC-1:0]             fast_pend,
   input  logic [NUM_SRC-1:0]             norm_pend,
   input  logic [NUM_SRC-1:0]             en_q,
   input  logic [NUM_SRC-1:0][PRIO_W-1:0] prio_q,
   input  logic                           ctrl_mode,
   input  logic [31:0]                    base_q,
   output logic [31:0]                    entry_q,
   output logic                           fast_int_o,
   output logic                           norm_int_o
);
   localparam int IDX_W = $clog2(NUM_SRC);
   localparam int PAD_W = 32 - IDX_W - 3;

   logic [NUM_SRC-1:0] fast_act, norm_act, cand;
   logic               win_vld;
   logic [IDX_W-1:0]   win_idx;
   logic [31:0]        entry_d;

   assign fast_act = fast_pend & en_q;
   assign norm_act = norm_pend & en_q;
   assign cand     = ctrl_mode ? norm_act : (fast_act | norm_act);

   pvic_arbiter #(
      .NUM_SRC (NUM_SRC),
      .PRIO_W  (PRIO_W),
      .ARB_TREE(ARB_TREE)
   ) u_arb (
      .act    (cand),
      .prio   (prio_q),
      .win_vld(win_vld),
      .win_idx(win_idx)
   );

   assign entry_d = win_vld
      ? base_q + {{PAD_W{1'b0}}, ({1'b0, win_idx} + 1'b1), 2'b00}
      : base_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         entry_q    <= '0;
         fast_int_o <= 1'b0;
         norm_int_o <= 1'b0;
      end else begin
         entry_q    <= entry_d;
         fast_int_o <= |fast_act;
         norm_int_o <= |norm_act;
      end
   end
endmodule

// File: rtl/prio_vec_intc.sv
module prio_vec_intc #(
   parameter int NUM_SRC  = 64,
   parameter int ADDR_W   = 12,
   parameter int PRIO_W   = 3,
   parameter int FAST_MAX = 1,
   parameter bit ARB_TREE = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] src_req,
   input  logic               bus_wr,
   input  logic               bus_rd,
   input  logic [ADDR_W-1:0]  bus_addr,
   input  logic [31:0]        bus_wdata,
   output logic [31:0]        bus_rdata,
   output logic               fast_int_o,
   output logic               norm_int_o
);
   if (NUM_SRC % 32 != 0 || NUM_SRC < 32 || NUM_SRC > 64) begin : g_bad_src
      $error("NUM_SRC must be 32 or 64");
   end
   if (PRIO_W < 1 || PRIO_W > 3) begin : g_bad_prio
      $error("PRIO_W must fit a nibble with one spare bit");
   end
   if (ADDR_W < 9) begin : g_bad_addr
      $error("ADDR_W must cover bits 7..2 and at least one ignored bit");
   end
   if (FAST_MAX < 0 || FAST_MAX >= (1 << PRIO_W)) begin : g_bad_fast
      $error("FAST_MAX out of priority range");
   end

   logic [NUM_SRC-1:0]             fast_pend, norm_pend, en_q;
   logic [NUM_SRC-1:0][PRIO_W-1:0] prio_q;
   logic                           ctrl_mode;
   logic [31:0]                    base_q, entry_q;

   pvic_regfile #(
      .NUM_SRC (NUM_SRC),
      .ADDR_W  (ADDR_W),
      .PRIO_W  (PRIO_W),
      .FAST_MAX(FAST_MAX)
   ) u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .src_req  (src_req),
      .bus_wr   (bus_wr),
      .bus_rd   (bus_rd),
      .bus_addr (bus_addr),
      .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata),
      .entry_q  (entry_q),
      .fast_pend(fast_pend),
      .norm_pend(norm_pend),
      .en_q     (en_q),
      .prio_q   (prio_q),
      .ctrl_mode(ctrl_mode),
      .base_q   (base_q)
   );

   pvic_entry #(
      .NUM_SRC (NUM_SRC),
      .PRIO_W  (PRIO_W),
      .ARB_TREE(ARB_TREE)
   ) u_entry (
      .clk       (clk),
      .rst_n     (rst_n),
      .fast_pend (fast_pend),
      .norm_pend (norm_pend),
      .en_q      (en_q),
      .prio_q    (prio_q),
      .ctrl_mode (ctrl_mode),
      .base_q    (base_q),
      .entry_q   (entry_q),
      .fast_int_o(fast_int_o),
      .norm_int_o(norm_int_o)
   );
endmodule

// File: rtl/pvic_checker.sv
module pvic_checker
   import pvic_pkg::*;
#(
   parameter int NUM_SRC = 64
) (
   input logic               clk,
   input logic               rst_n,
   input logic [NUM_SRC-1:0] src_req,
   input logic               bus_wr,
   input logic [WIDX_W-1:0]  wr_widx,
   input logic [31:0]        bus_wdata,
   input logic [NUM_SRC-1:0] fast_pend,
   input logic [NUM_SRC-1:0] norm_pend,
   input logic [NUM_SRC-1:0] en_q,
   input logic               ctrl_mode,
   input logic [31:0]        base_q,
   input logic [31:0]        entry_q,
   input logic               fast_int_o,
   input logic               norm_int_o
);
   logic live;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) live <= 1'b0;
      else        live <= 1'b1;
   end

   a_r2_norm_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && wr_widx == WIDX_W'(W_NPEND))
      |=> ((norm_pend[31:0] & $past(bus_wdata & ~src_req[31:0])) == 32'b0));

   a_r5_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
      (|src_req) |=> (((fast_pend | norm_pend) & $past(src_req)) == $past(src_req)));

   a_r6_fast_line: assert property (@(posedge clk) disable iff (!rst_n)
      live |-> (fast_int_o == $past(|(fast_pend & en_q))));

   a_r6_norm_line: assert property (@(posedge clk) disable iff (!rst_n)
      live |-> (norm_int_o == $past(|(norm_pend & en_q))));

   a_r8_empty_entry: assert property (@(posedge clk) disable iff (!rst_n)
      (live && $past(((fast_pend | norm_pend) & en_q) == '0)) |-> (entry_q == $past(base_q)));

   a_r7_fast_wins_entry: assert property (@(posedge clk) disable iff (!rst_n)
      (live && $past(!ctrl_mode) && fast_int_o) |-> (entry_q != $past(base_q)));

   a_r3_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (live && $past(en_q) == '0) |-> (!fast_int_o && !norm_int_o));
endmodule

bind prio_vec_intc pvic_checker #(.NUM_SRC(NUM_SRC)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .src_req   (src_req),
   .bus_wr    (bus_wr),
   .wr_widx   (bus_addr[7:2]),
   .bus_wdata (bus_wdata),
   .fast_pend (fast_pend),
   .norm_pend (norm_pend),
   .en_q      (en_q),
   .ctrl_mode (ctrl_mode),
   .base_q    (base_q),
   .entry_q   (entry_q),
   .fast_int_o(fast_int_o),
   .norm_int_o(norm_int_o)
);

// File: tb/test_prio_vec_intc.sv
`timescale 1ns/1ps
module test_prio_vec_intc;
   localparam int NS = 64;
   localparam int AW = 12;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [NS-1:0] src_req = '0;
   logic          bus_wr = 1'b0;
   logic          bus_rd = 1'b0;
   logic [AW-1:0] bus_addr = '0;
   logic [31:0]   bus_wdata = '0;
   logic [31:0]   bus_rdata;
   logic          fast_int_o, norm_int_o;

   int n_chk = 0;
   int n_fail = 0;

   typedef struct {
      logic [31:0] rd;
      logic        f;
      logic        n;
      string       tag;
   } exp_t;
   exp_t sb_q[$];

   always #5 clk = ~clk;

   prio_vec_intc #(.NUM_SRC(NS), .ADDR_W(AW)) i_prio_vec_intc (
      .clk(clk), .rst_n(rst_n), .src_req(src_req),
      .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .fast_int_o(fast_int_o), .norm_int_o(norm_int_o)
   );

   // monitor: pops one expected item per read window
   always @(negedge clk) begin
      if (bus_rd) begin
         n_chk++;
         if (sb_q.size() == 0) begin
            n_fail++;
            $display("FAIL unexpected read: rdata=%h", bus_rdata);
         end else begin
            exp_t e;
            e = sb_q.pop_front();
            if (bus_rdata !== e.rd || fast_int_o !== e.f || norm_int_o !== e.n) begin
               n_fail++;
               $display("FAIL %s: rdata=%h exp %h, fast=%b exp %b, norm=%b exp %b",
                        e.tag, bus_rdata, e.rd, fast_int_o, e.f, norm_int_o, e.n);
            end
         end
      end
   end

   task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
      @(negedge clk); #1;
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk); #1;
      bus_wr = 1'b0;
   endtask

   task automatic pulse(input logic [NS-1:0] v);
      @(negedge clk); #1;
      src_req = v;
      @(negedge clk); #1;
      src_req = '0;
   endtask

   task automatic wr_pulse(input logic [AW-1:0] a, input logic [31:0] d, input logic [NS-1:0] v);
      @(negedge clk); #1;
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d; src_req = v;
      @(negedge clk); #1;
      bus_wr = 1'b0; src_req = '0;
   endtask

   task automatic rd_chk(input logic [AW-1:0] a, input logic [31:0] d,
                         input logic f, input logic n, input string tag);
      exp_t e;
      e.rd = d; e.f = f; e.n = n; e.tag = tag;
      sb_q.push_back(e);
      @(negedge clk); #1;
      bus_rd = 1'b1; bus_addr = a;
      @(negedge clk); #1;
      bus_rd = 1'b0;
   endtask

   initial begin
      #2_000_000;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk); rst_n = 1'b1;

      // R12 reset state
      rd_chk(12'h000, 32'h0, 0, 0, "R12 fast pending");
      rd_chk(12'h00C, 32'h0, 0, 0, "R12 normal pending");
      rd_chk(12'h018, 32'h0, 0, 0, "R12 enable");
      rd_chk(12'h020, 32'h0, 0, 0, "R12 control");
      rd_chk(12'h024, 32'h0, 0, 0, "R12 base");
      rd_chk(12'h014, 32'h0, 0, 0, "R12 entry");

      // R4 priority storage: spare nibble bit reads 0
      wr(12'h030, 32'hFFFF_FFFF);
      rd_chk(12'h030, 32'h7777_7777, 0, 0, "R4 spare bit");
      for (int r = 1; r < 8; r++) wr(AW'(12'h030 + 4*r), 32'h7777_7777);
      wr(12'h030, 32'h7771_0777);   // src3 prio0, src4 prio1
      wr(12'h034, 32'h7777_7277);   // src10 prio2
      wr(12'h044, 32'h7777_7755);   // src40,41 prio5
      rd_chk(12'h044, 32'h7777_7755, 0, 0, "R4 nibble placement");

      // R1 normal capture, R3/R8 masked
      pulse(64'h3 << 40);
      rd_chk(12'h00C, 32'h0000_0300, 0, 0, "R1 normal bank word1");
      rd_chk(12'h004, 32'h0, 0, 0, "R1 fast bank word1 empty");
      rd_chk(12'h014, 32'h0, 0, 0, "R8 masked gives base");

      // R7 tie -> lowest index, R6 normal line
      wr(12'h01C, 32'h0000_0300);
      rd_chk(12'h01C, 32'h0000_0300, 0, 1, "R3 enable readback");
      rd_chk(12'h014, 32'h0000_00A4, 0, 1, "R7 tie lowest index");

      // R1 class boundary (prio1 fast, prio2 normal)
      pulse((64'h1 << 3) | (64'h1 << 4) | (64'h1 << 10));
      rd_chk(12'h000, 32'h0000_0018, 0, 1, "R1 fast bank prio0/1");
      rd_chk(12'h008, 32'h0000_0400, 0, 1, "R1 normal bank prio2");
      wr(12'h018, 32'h0000_0418);
      rd_chk(12'h014, 32'h0000_0010, 1, 1, "R7 lowest priority value wins");

      // R10 normal-only mode
      wr(12'h020, 32'hFFFF_FFFF);
      rd_chk(12'h020, 32'h1, 1, 1, "R10 control readback");
      rd_chk(12'h014, 32'h0000_002C, 1, 1, "R10 normal only");

      // R9 base
      wr(12'h024, 32'h1000_0003);
      rd_chk(12'h024, 32'h1000_0000, 1, 1, "R9 base low bits");
      rd_chk(12'h014, 32'h1000_002C, 1, 1, "R9 entry with base");

      // R3 disable takes effect at once
      wr(12'h018, 32'h0000_0018);
      rd_chk(12'h014, 32'h1000_00A4, 1, 1, "R3 disable immediate");
      rd_chk(12'h008, 32'h0000_0400, 1, 1, "R3 pending kept");

      // R2 write-one-to-clear, zero no effect
      wr(12'h00C, 32'h0000_0100);
      rd_chk(12'h00C, 32'h0000_0200, 1, 1, "R2 clear one bit");
      rd_chk(12'h014, 32'h1000_00A8, 1, 1, "R2 next winner");
      wr(12'h00C, 32'h0);
      rd_chk(12'h00C, 32'h0000_0200, 1, 1, "R2 zero no effect");

      // R5 set beats clear
      wr_pulse(12'h00C, 32'h0000_0200, 64'h1 << 41);
      rd_chk(12'h00C, 32'h0000_0200, 1, 1, "R5 set wins");
      wr(12'h00C, 32'h0000_0200);
      rd_chk(12'h00C, 32'h0, 1, 0, "R2 clear last normal");
      rd_chk(12'h014, 32'h1000_0000, 1, 0, "R8 no normal candidate");

      // R10 both banks again
      wr(12'h020, 32'h0);
      rd_chk(12'h014, 32'h1000_0010, 1, 0, "R10 both banks");

      // R11 decode
      rd_chk(12'h010, 32'h0, 1, 0, "R11 undefined 0x10");
      rd_chk(12'h028, 32'h0, 1, 0, "R11 undefined 0x28");
      rd_chk(12'h114, 32'h1000_0010, 1, 0, "R11 high bits ignored");

      // R2/R8/R6 drain fast bank
      wr(12'h000, 32'h0000_0018);
      rd_chk(12'h000, 32'h0, 0, 0, "R2 fast clear");
      rd_chk(12'h014, 32'h1000_0000, 0, 0, "R8 empty after drain");

      repeat (2) @(negedge clk);
      if (sb_q.size() != 0) begin
         n_fail++;
         $display("FAIL scoreboard not drained: %0d left, expected 0", sb_q.size());
      end
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule